// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt sources for a small processor core. The sources are a reset pin, a non-maskable edge input, three external edge inputs with programmable polarity, and three request lines from on-chip peripherals (timer, serial port, end-of-message). Each detected event sets a bit in a pending register. A fixed-rank arbiter selects the most urgent request that is allowed to proceed. The controller then emits a one-cycle acknowledge that carries the source index and the 16-bit address of the vector word for that source.

A reset request is taken at once. Every other request waits for the core to report an instruction boundary. Accepting any request clears the global enable. A return-from-interrupt pulse or a dedicated set pulse turns it back on, so the service routine can re-enable early to allow nesting. Software reaches the pending, enable and polarity state through a small register port with a registered read path.

Top module: `vec_irq_ctrl`

## Requirements
- R1: When several requests are eligible, the acknowledge selects the lowest source index. The ranking from index 0 to 7 is reset, non-maskable, ext2, ext3, ext4, timer, serial, end-of-message.
- R2: While `ack` is high, `ack_vec` equals 16'hFFFE minus twice `ack_idx`. This gives FFFE for reset, FFFC for the non-maskable input and FFF0 for end-of-message.
- R3: A pending reset is acknowledged whatever the state of `insn_done`. All other sources are acknowledged only at a clock edge where `insn_done` is high.
- R4: While the synchronised `rst_pin_n` is low, `core_hold` is high, no acknowledge is issued, writes are ignored and pending, enable and polarity return to their reset values. A rising edge on the pin raises a reset request.
- R5: The non-maskable input reacts to rising edges. The polarity register (address 2, bit j for ext input j) selects rising edges when the bit is 1 and falling edges when it is 0. It resets to all ones.
- R6: A maskable source (index 2 to 7) needs its enable bit (address 1, bit = source index) and the global enable (address 1, bit 0) both set. Reset and non-maskable requests ignore both.
- R7: A detected event sets its pending bit (address 0, bit = source index) even when the source is disabled.
- R8: An acknowledge clears the global enable. A `reti` or `gie_set` pulse sets it, and so does a write to address 1 with bit 0 set.
- R9: Acknowledging reset, the non-maskable input or an external input clears that pending bit. Acknowledging a peripheral source leaves its pending bit set.
- R10: Writing address 0 clears every pending bit written as 1 and leaves the others unchanged.
- R11: `ack` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | Asynchronous reset-request pin, active low |
| nmi_pin | input | 1 | Non-maskable edge input |
| ext_pin | input | 3 | External edge inputs ext2..ext4 |
| per_req | input | 3 | Peripheral requests: timer, serial, end-of-message |
| insn_done | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt pulse |
| gie_set | input | 1 | Set global enable pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 pending, 1 enable, 2 polarity |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` of the previous cycle |
| ack | output | 1 | Acknowledge pulse |
| ack_vec | output | 16 | Vector word address of the accepted source |
| ack_idx | output | 3 | Index of the accepted source |
| core_hold | output | 1 | Core held in reset |

## Verification
A corrupted pending bit shows up within one cycle of a read of address 0. If it belongs to an eligible source, it also appears as an extra or missing acknowledge at the next instruction boundary. A global enable stuck high gives a second maskable acknowledge on the cycle after the first. A wrong edge polarity or a wrong synchroniser depth shows as a pending bit or acknowledge at the wrong edge, or one cycle early or late, against the cycle-exact model. A stuck arbiter shows the moment two sources are pending together.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [15:0] VEC_TOP = 16'hFFFE;

  typedef enum logic [1:0] {
    RA_PEND = 2'd0,
    RA_EN   = 2'd1,
    RA_POL  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/vic_edge.sv
module vic_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic rise_sel,
  output logic evt
);
  logic cur, prev;

  generate
    if (STAGES > 0) begin : g_sync
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh <= '0;
        end else begin
          sh[0] <= din;
          for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
        end
      end
      assign cur = sh[STAGES-1];
    end else begin : g_direct
      assign cur = din;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= cur;
  end

  assign evt = rise_sel ? (cur & ~prev) : (~cur & prev);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int N_EXT       = 3,
  parameter int N_PER       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  rst_pin_n,
  input  logic                                  nmi_pin,
  input  logic [N_EXT-1:0]                      ext_pin,
  input  logic [N_PER-1:0]                      per_req,
  input  logic                                  insn_done,
  input  logic                                  reti,
  input  logic                                  gie_set,
  input  logic                                  reg_wr,
  input  logic [1:0]                            reg_addr,
  input  logic [2+N_EXT+N_PER-1:0]              reg_wdata,
  output logic [2+N_EXT+N_PER-1:0]              reg_rdata,
  output logic                                  ack,
  output logic [15:0]                           ack_vec,
  output logic [$clog2(2+N_EXT+N_PER)-1:0]      ack_idx,
  output logic                                  core_hold
);
  import vic_pkg::*;

  localparam int NSRC      = 2 + N_EXT + N_PER;
  localparam int IDX_W     = $clog2(NSRC);
  localparam int FIRST_PER = 2 + N_EXT;
  localparam logic [NSRC-1:0] MASKABLE = ~NSRC'(3);
  localparam logic [NSRC-1:0] AUTO_CLR = NSRC'((1 << FIRST_PER) - 1);

  // reset pin synchroniser and edge compare
  logic [SYNC_STAGES-1:0] rsh;
  logic                   rprev;
  logic                   hold, rst_evt;

  assign hold      = ~rsh[SYNC_STAGES-1];
  assign rst_evt   = rsh[SYNC_STAGES-1] & ~rprev;
  assign core_hold = hold;

  // programmable state
  logic [NSRC-1:0]  pend, en;
  logic             gie;
  logic [N_EXT-1:0] pol;

  logic [NSRC-1:0] evt;
  assign evt[0] = rst_evt;

  vic_edge #(.STAGES(SYNC_STAGES)) u_nmi_edge (
    .clk(clk), .rst(rst), .din(nmi_pin), .rise_sel(1'b1), .evt(evt[1])
  );

  genvar gj;
  generate
    for (gj = 0; gj < N_EXT; gj++) begin : g_ext
      vic_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .din(ext_pin[gj]), .rise_sel(pol[gj]),
        .evt(evt[2+gj])
      );
    end
    for (gj = 0; gj < N_PER; gj++) begin : g_per
      vic_edge #(.STAGES(0)) u_edge (
        .clk(clk), .rst(rst), .din(per_req[gj]), .rise_sel(1'b1),
        .evt(evt[FIRST_PER+gj])
      );
    end
  endgenerate

  // eligibility and arbitration
  logic [NSRC-1:0]  req;
  logic             any_req, take;
  logic [IDX_W-1:0] win_idx;

  assign req = pend & (~MASKABLE | (en & {NSRC{gie}}));

  vic_arbiter #(.N(NSRC)) u_arb (
    .req(req), .any(any_req), .idx(win_idx)
  );

  assign take = ~hold & any_req & ((win_idx == '0) | insn_done);

  logic [NSRC-1:0] clr_ack, clr_sw;
  logic            wr_pend, wr_en, wr_pol;

  assign wr_pend = reg_wr && (reg_addr == RA_PEND);
  assign wr_en   = reg_wr && (reg_addr == RA_EN);
  assign wr_pol  = reg_wr && (reg_addr == RA_POL);
  assign clr_ack = take ? ((NSRC'(1) << win_idx) & AUTO_CLR) : '0;
  assign clr_sw  = wr_pend ? reg_wdata : '0;

  logic [NSRC-1:0] rd_mux;
  always_comb begin
    case (reg_addr)
      RA_PEND: rd_mux = pend;
      RA_EN:   rd_mux = (en & MASKABLE) | NSRC'(gie);
      RA_POL:  rd_mux = {{(NSRC-N_EXT){1'b0}}, pol};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsh       <= '1;
      rprev     <= 1'b1;
      pend      <= '0;
      en        <= '0;
      gie       <= 1'b0;
      pol       <= '1;
      ack       <= 1'b0;
      ack_vec   <= '0;
      ack_idx   <= '0;
      reg_rdata <= '0;
    end else begin
      rsh[0] <= rst_pin_n;
      for (int i = 1; i < SYNC_STAGES; i++) rsh[i] <= rsh[i-1];
      rprev     <= rsh[SYNC_STAGES-1];
      reg_rdata <= rd_mux;
      ack       <= take;
      if (take) begin
        ack_idx <= win_idx;
        ack_vec <= VEC_TOP - (16'(win_idx) << 1);
      end
      if (hold) begin
        pend <= '0;
        en   <= '0;
        gie  <= 1'b0;
        pol  <= '1;
      end else begin
        pend <= (pend & ~clr_sw & ~clr_ack) | evt;
        if (wr_en)  en  <= reg_wdata & MASKABLE;
        if (wr_pol) pol <= reg_wdata[N_EXT-1:0];
        if (take)                gie <= 1'b0;
        else if (reti | gie_set) gie <= 1'b1;
        else if (wr_en)          gie <= reg_wdata[0];
      end
    end
  end
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             insn_done,
  input logic             ack,
  input logic [15:0]      ack_vec,
  input logic [IDX_W-1:0] ack_idx,
  input logic             core_hold
);
  AST_VEC_FOR_IDX: assert property (@(posedge clk) disable iff (rst)
    ack |-> (ack_vec == 16'hFFFE - (16'(ack_idx) << 1))); // R2

  AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_idx != '0) |-> $past(insn_done)); // R3

  AST_QUIET_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (core_hold && $past(core_hold)) |-> !ack); // R4

  AST_MASKED_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_idx >= IDX_W'(2)) |=> !(ack && ack_idx >= IDX_W'(2))); // R8
endmodule

bind vec_irq_ctrl vic_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .insn_done(insn_done), .ack(ack),
  .ack_vec(ack_vec), .ack_idx(ack_idx), .core_hold(core_hold)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_pin_n = 1'b1, nmi_pin = 1'b0;
  logic [2:0] ext_pin = '0, per_req = '0;
  logic       insn_done = 1'b1, reti = 1'b0, gie_set = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ack, core_hold;
  logic [15:0] ack_vec;
  logic [2:0] ack_idx;

  int checks = 0, failures = 0;
  int ack_log[$];
  logic [15:0] last_vec;
  int run = 0, max_run = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .nmi_pin(nmi_pin),
    .ext_pin(ext_pin), .per_req(per_req), .insn_done(insn_done),
    .reti(reti), .gie_set(gie_set), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack),
    .ack_vec(ack_vec), .ack_idx(ack_idx), .core_hold(core_hold)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model, stepped on every rising edge
  bit       m_r1, m_r2, m_rp;
  bit [7:0] m_s1, m_s2, m_pv, m_pend, m_en, m_rdata;
  bit [2:0] m_pol;
  bit       m_gie, m_ack;
  int       m_idx;

  always @(posedge clk) begin
    if (rst) begin
      m_r1 = 1; m_r2 = 1; m_rp = 1; m_s1 = 0; m_s2 = 0; m_pv = 0;
      m_pend = 0; m_en = 0; m_gie = 0; m_pol = 3'b111; m_ack = 0;
      m_idx = 0; m_rdata = 0;
    end else begin
      bit hold, take;
      bit [7:0] ev;
      int win;
      hold = !m_r2;
      ev[0] = m_r2 && !m_rp;
      for (int i = 1; i < 5; i++) begin
        bit rising;
        rising = (i == 1) || m_pol[i-2];
        ev[i] = rising ? (m_s2[i] && !m_pv[i]) : (!m_s2[i] && m_pv[i]);
      end
      for (int i = 5; i < 8; i++) ev[i] = per_req[i-5] && !m_pv[i];
      win = -1;
      for (int i = 0; i < 8; i++)
        if (win < 0 && m_pend[i] && (i < 2 || (m_en[i] && m_gie))) win = i;
      take = !hold && win >= 0 && (win == 0 || insn_done);
      case (reg_addr)
        2'd0: m_rdata = m_pend;
        2'd1: m_rdata = m_en | {7'd0, m_gie};
        2'd2: m_rdata = {5'd0, m_pol};
        default: m_rdata = 0;
      endcase
      for (int i = 1; i < 5; i++) begin
        bit pin;
        pin = (i == 1) ? nmi_pin : ext_pin[i-2];
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pin;
      end
      for (int i = 5; i < 8; i++) m_pv[i] = per_req[i-5];
      m_rp = m_r2; m_r2 = m_r1; m_r1 = rst_pin_n;
      m_ack = take;
      if (take) m_idx = win;
      if (hold) begin
        m_pend = 0; m_en = 0; m_gie = 0; m_pol = 3'b111;
      end else begin
        if (reg_wr && reg_addr == 2'd0) m_pend &= ~reg_wdata;
        if (take && win < 5) m_pend[win] = 0;
        m_pend |= ev;
        if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata & 8'hFC;
        if (reg_wr && reg_addr == 2'd2) m_pol = reg_wdata[2:0];
        if (take) m_gie = 0;
        else if (reti || gie_set) m_gie = 1;
        else if (reg_wr && reg_addr == 2'd1) m_gie = reg_wdata[0];
      end
    end
  end

  // compare against the model between edges
  always @(negedge clk) begin
    if (!rst) begin
      check(ack == m_ack, "R11", "ack vs model", ack, m_ack);
      if (m_ack) begin
        check(ack_idx == 3'(m_idx), "R1", "ack_idx vs model", ack_idx, m_idx);
        check(ack_vec == 16'hFFFE - 16'(2 * m_idx), "R2", "ack_vec vs model",
              ack_vec, 16'hFFFE - 16'(2 * m_idx));
      end
      check(core_hold == !m_r2, "R4", "core_hold vs model", core_hold, !m_r2);
      check(reg_rdata == m_rdata, "R7", "reg_rdata vs model", reg_rdata, m_rdata);
      if (ack) begin
        ack_log.push_back(int'(ack_idx));
        last_vec = ack_vec;
        run++;
        if (run > max_run) max_run = run;
      end else begin
        run = 0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20ns * 50000);
    failures++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    summary();
  end

  initial begin
    logic [7:0] d;
    idle(3);
    rst = 0;
    idle(1);
    check(ack == 0 && core_hold == 0, "R4", "reset outputs", {ack, core_hold}, 0);
    rd(2, d); check(d == 8'h07, "R5", "polarity reset value", d, 8'h07);
    rd(1, d); check(d == 8'h00, "R6", "enables reset value", d, 8'h00);

    // reset pin hold and release
    insn_done = 0;
    @(negedge clk); rst_pin_n = 0;
    idle(5);
    check(core_hold == 1, "R4", "hold while pin low", core_hold, 1);
    wr(1, 8'hFF);
    rd(1, d); check(d == 8'h00, "R4", "write ignored in hold", d, 0);
    ack_log.delete();
    rst_pin_n = 1;
    idle(6);
    check(ack_log.size() == 1 && ack_log[0] == 0, "R3", "reset taken without boundary",
          ack_log.size(), 1);
    check(last_vec == 16'hFFFE, "R2", "reset vector", last_vec, 16'hFFFE);
    rd(0, d); check(d == 8'h00, "R9", "reset pending auto-cleared", d, 0);
    insn_done = 1;

    // disabled peripheral latches pending
    ack_log.delete();
    @(negedge clk); per_req[0] = 1;
    @(negedge clk); per_req[0] = 0;
    idle(3);
    check(ack_log.size() == 0, "R6", "disabled source not taken", ack_log.size(), 0);
    rd(0, d); check(d == 8'h20, "R7", "pending latched while disabled", d, 8'h20);
    wr(0, 8'h20);
    rd(0, d); check(d == 8'h00, "R10", "write one clears pending", d, 0);

    // enabled peripheral is taken
    wr(1, 8'hFD);
    rd(1, d); check(d == 8'hFD, "R6", "enables written", d, 8'hFD);
    @(negedge clk); per_req[0] = 1;
    @(negedge clk); per_req[0] = 0;
    idle(4);
    check(ack_log.size() == 1 && ack_log[0] == 5, "R6", "timer taken when enabled",
          ack_log.size(), 1);
    check(last_vec == 16'hFFF4, "R2", "timer vector", last_vec, 16'hFFF4);
    rd(1, d); check(d == 8'hFC, "R8", "global enable cleared on accept", d, 8'hFC);
    rd(0, d); check(d == 8'h20, "R9", "peripheral pending kept", d, 8'h20);
    wr(0, 8'h20);

    // simultaneous external requests
    @(negedge clk); gie_set = 1;
    @(negedge clk); gie_set = 0;
    rd(1, d); check(d == 8'hFD, "R8", "gie_set sets global enable", d, 8'hFD);
    ack_log.delete();
    insn_done = 0;
    ext_pin[0] = 1; ext_pin[2] = 1;
    idle(5);
    rd(0, d); check(d == 8'h14, "R7", "two external pending", d, 8'h14);
    check(ack_log.size() == 0, "R3", "no accept without boundary", ack_log.size(), 0);
    insn_done = 1;
    idle(3);
    rd(0, d); check(d == 8'h10, "R9", "external pending auto-cleared", d, 8'h10);
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
    idle(3);
    check(ack_log.size() == 2 && ack_log[0] == 2 && ack_log[1] == 4, "R1",
          "rank order ext2 then ext4", ack_log.size(), 2);
    rd(1, d); check(d == 8'hFC, "R8", "gie cleared after second accept", d, 8'hFC);

    // falling-edge polarity
    wr(2, 8'h00);
    @(negedge clk); ext_pin[1] = 1;
    idle(5);
    rd(0, d); check(d == 8'h00, "R5", "rising edge ignored when falling selected", d, 0);
    @(negedge clk); ext_pin[1] = 0;
    idle(5);
    rd(0, d); check(d == 8'h08, "R5", "falling edge detected", d, 8'h08);
    wr(0, 8'h08);
    wr(2, 8'h07);

    // non-maskable ignores global enable
    ack_log.delete();
    @(negedge clk); nmi_pin = 1;
    idle(3); nmi_pin = 0;
    idle(4);
    check(ack_log.size() == 1 && ack_log[0] == 1, "R6", "nmi taken with gie clear",
          ack_log.size(), 1);
    check(last_vec == 16'hFFFC, "R2", "nmi vector", last_vec, 16'hFFFC);
    rd(0, d); check(d == 8'h00, "R9", "nmi pending auto-cleared", d, 0);

    // end-of-message waits for global enable
    ack_log.delete();
    @(negedge clk); per_req[2] = 1;
    @(negedge clk); per_req[2] = 0;
    idle(3);
    check(ack_log.size() == 0, "R6", "eom blocked by global enable", ack_log.size(), 0);
    @(negedge clk); gie_set = 1;
    @(negedge clk); gie_set = 0;
    idle(3);
    check(ack_log.size() == 1 && ack_log[0] == 7, "R1", "eom taken", ack_log.size(), 1);
    check(last_vec == 16'hFFF0, "R2", "eom vector", last_vec, 16'hFFF0);
    rd(0, d); check(d == 8'h80, "R9", "eom pending kept", d, 8'h80);
    wr(0, 8'h80);
    rd(0, d); check(d == 8'h00, "R10", "eom pending cleared by write", d, 0);

    check(max_run == 1, "R11", "acknowledge pulse width", max_run, 1);
    summary();
  end
endmodule